// File: doc/BRIEF.md
# Compact Programmable State Machine Core

This block is a small sequencing processor meant to replace a hand-written controller when the control flow is too involved for a fixed state machine. It reads one 12-bit instruction word per step from a program store outside the block, addressed by its own program-address output, and carries out that word against sixteen registers of parameterised data width. Two small tables live inside the block as parameters. One holds sixteen data-width constants and the other holds sixteen absolute program addresses. An instruction reaches either table only through a 4-bit index, so the data width never depends on the instruction width.

Data enters through sixteen input ports and leaves through sixteen registered output ports. Every output write raises a one-cycle strobe together with the port index and the value. Two flags, zero and carry, are set by arithmetic, logic and shift operations, and conditional jumps test them. The sequencer has six named states. ST_FETCH decodes the word on the instruction bus. A jump word finishes in ST_FETCH and stays there. Any other word is latched and moves to ST_OPA, which reads sx. ST_OPB then selects and reads the second operand, which is a register, a table constant or an input port. ST_EXEC computes the result and the flags, ST_WB writes the result back or strobes the output, and ST_NEXT increments the program address and returns to ST_FETCH.

Top module: `tiny_ctrl_core`

## Requirements
- R1: While reset is held and on its release, the following are zero: the program address, both flags, all sixteen registers and all output-port registers. The output strobe is low.
- R2: Any word whose bits 11:8 are not 0111 takes exactly six cycles. The program address holds steady for those cycles and increases by one at their end.
- R3: A word with bits 11:8 = 0111 takes one cycle, whether the jump is taken or not. Bit 7 enables a test that carry equals bit 6. Bit 5 enables a test that zero equals bit 4. If every enabled test holds, the next address is jump-table entry bits 3:0. Otherwise the next address is the current address plus one.
- R4: Opcode 1101 sets sx (bits 7:4) to sx + sy (sy is bits 3:0) + carry. Opcode 1100 sets sx to sx − sy − carry. Carry takes the carry out, or the borrow for subtraction. Zero is set when the data-width result is zero.
- R5: Opcodes 1000, 1001 and 1010 set sx to sx OR, AND or XOR sy. They clear carry and set zero from the result. Opcode 1011 copies sy into sx and leaves both flags unchanged.
- R6: Opcodes 0101, 0100, 0000, 0001, 0010 and 0011 act like 1101, 1100, 1000, 1001, 1010 and 1011. The difference is that the second operand is constant-table entry bits 3:0.
- R7: Opcode 1110 loads sx from input port bits 3:0. The port is sampled only at the end of the third cycle of the instruction. The flags do not change.
- R8: Opcode 1111 raises the output strobe for exactly one cycle, the fifth of the instruction, with the port index bits 3:0 and the value of sx. From the next cycle, output-port register bits 3:0 holds that value until another write to that port. The flags do not change.
- R9: Opcode 0110 shifts sx by one bit. Bit 3 of the word sets the direction (1 means right). Bits 2:1 choose the incoming bit: 00 is carry, 01 is the old most significant bit, 10 is the old least significant bit and 11 is bit 0 of the word. Carry takes the bit shifted out, and zero is set from the result.
- R10: Stepping past the last address, 2^PAW − 1, wraps the program address to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 12 | Instruction word at the current program address |
| pc_o | output | PAW | Current program address |
| in_ports_i | input | 16*DW | Sixteen input ports, port k at bits k*DW +: DW |
| out_ports_o | output | 16*DW | Sixteen registered output ports, same packing |
| out_wr_o | output | 1 | One-cycle output write strobe |
| out_sel_o | output | 4 | Index of the output port being written |
| out_data_o | output | DW | Value being written to the output port |

## Verification
The bench first runs a shift-and-add 4×4 multiply program over directed operand pairs: both nibbles at their maximum, one nibble zero, and some random pairs. Only correct carry chaining through add, the carry-fed right shift and the borrow-aware loop counter give the right product, so this run separates those three. A directed prologue after a second reset shows that both flags start clear, that the address wraps from the top of memory, and that a carry produced there steers a conditional jump. The rest of the run executes random instruction words against a per-instruction reference model. Input ports hold a decoy value in every cycle except the sampling cycle, and output data and flag-driven jump outcomes are checked against the instruction that last wrote the register or the flags. This separates operand-source selection, flag update rules and sampling-cycle errors.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int INSTR_W = 12;
    localparam int SEL_W   = 4;
    localparam int N_SLOT  = 1 << SEL_W;

    localparam logic [3:0] OPC_SHIFT = 4'b0110;
    localparam logic [3:0] OPC_JUMP  = 4'b0111;
    localparam logic [3:0] OPC_IN    = 4'b1110;
    localparam logic [3:0] OPC_OUT   = 4'b1111;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_OPA   = 3'd1,
        ST_OPB   = 3'd2,
        ST_EXEC  = 3'd3,
        ST_WB    = 3'd4,
        ST_NEXT  = 3'd5
    } tcc_state_e;

endpackage

// File: rtl/tcc_sequencer.sv
module tcc_sequencer
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_jump_i,
    output tcc_state_e state_o,
    output logic       jump_now_o,
    output logic       ld_ir_o,
    output logic       ld_a_o,
    output logic       ld_b_o,
    output logic       ld_res_o,
    output logic       wb_o,
    output logic       step_o
);

    tcc_state_e state_q;
    tcc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH: state_d = fetch_jump_i ? ST_FETCH : ST_OPA;
            ST_OPA:   state_d = ST_OPB;
            ST_OPB:   state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_WB;
            ST_WB:    state_d = ST_NEXT;
            ST_NEXT:  state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        jump_now_o = 1'b0;
        ld_ir_o    = 1'b0;
        ld_a_o     = 1'b0;
        ld_b_o     = 1'b0;
        ld_res_o   = 1'b0;
        wb_o       = 1'b0;
        step_o     = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                jump_now_o = fetch_jump_i;
                ld_ir_o    = !fetch_jump_i;
            end
            ST_OPA:  ld_a_o   = 1'b1;
            ST_OPB:  ld_b_o   = 1'b1;
            ST_EXEC: ld_res_o = 1'b1;
            ST_WB:   wb_o     = 1'b1;
            ST_NEXT: step_o   = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R2: the operand phases run in a fixed order
    p_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPA) |=> (state_q == ST_OPB));

    // R2: the last phase always hands back to fetch
    p_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEXT) |=> (state_q == ST_FETCH));

    // R3: a jump never leaves the fetch state
    p_jump_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && fetch_jump_i) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/tcc_alu.sv
module tcc_alu
    import tcc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op_i,
    input  logic [3:0]    sub_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o,
    output logic          zout_o,
    output logic          flag_we_o
);

    logic [DW:0] wide;
    logic        fill;

    always_comb begin
        res_o     = b_i;
        cout_o    = cin_i;
        flag_we_o = 1'b0;
        wide      = '0;
        fill      = 1'b0;
        if (!op_i[2]) begin
            unique case (op_i[1:0])
                2'b00: res_o = a_i | b_i;
                2'b01: res_o = a_i & b_i;
                2'b10: res_o = a_i ^ b_i;
                default: res_o = b_i;
            endcase
            if (op_i[1:0] != 2'b11) begin
                cout_o    = 1'b0;
                flag_we_o = 1'b1;
            end
        end else if (!op_i[1]) begin
            if (op_i[0])
                wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
            else
                wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
            res_o     = wide[DW-1:0];
            cout_o    = wide[DW];
            flag_we_o = 1'b1;
        end else if (op_i == OPC_SHIFT) begin
            unique case (sub_i[2:1])
                2'b00: fill = cin_i;
                2'b01: fill = a_i[DW-1];
                2'b10: fill = a_i[0];
                default: fill = sub_i[0];
            endcase
            if (sub_i[3]) begin
                res_o  = {fill, a_i[DW-1:1]};
                cout_o = a_i[0];
            end else begin
                res_o  = {a_i[DW-2:0], fill};
                cout_o = a_i[DW-1];
            end
            flag_we_o = 1'b1;
        end
        zout_o = (res_o == '0);
    end

endmodule

// File: rtl/tcc_regfile.sv
module tcc_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_a_o,
    output logic [DW-1:0] rdata_b_o
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (we_i && (waddr_i == AW'(g)))      q <= wdata_i;
        end
        assign regs[g] = q;
    end

    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];

    // R4: a written value is what the addressed entry reads back next cycle
    p_wr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/tiny_ctrl_core.sv
module tiny_ctrl_core
    import tcc_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PAW = 8,
    parameter logic [N_SLOT*DW-1:0]  CONST_INIT = '0,
    parameter logic [N_SLOT*PAW-1:0] JUMP_INIT  = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [INSTR_W-1:0]     instr_i,
    output logic [PAW-1:0]         pc_o,
    input  logic [N_SLOT*DW-1:0]   in_ports_i,
    output logic [N_SLOT*DW-1:0]   out_ports_o,
    output logic                   out_wr_o,
    output logic [SEL_W-1:0]       out_sel_o,
    output logic [DW-1:0]          out_data_o
);

    tcc_state_e state;
    logic jump_now, ld_ir, ld_a, ld_b, ld_res, wb, step;

    logic [INSTR_W-1:0] ir_q;
    logic [3:0]         op_q, sx_q, sy_q;
    logic [DW-1:0]      opa_q, opb_q, res_q, opb_d;
    logic               flag_c_q, flag_z_q;
    logic [PAW-1:0]     pc_q;
    logic [DW-1:0]      outp_q [N_SLOT];

    logic [DW-1:0]  rf_a, rf_b, const_val, port_val, alu_res;
    logic           alu_c, alu_z, alu_fw;
    logic           fetch_jump, jump_take;
    logic [PAW-1:0] jump_tgt;

    assign op_q = ir_q[11:8];
    assign sx_q = ir_q[7:4];
    assign sy_q = ir_q[3:0];

    assign fetch_jump = (instr_i[11:8] == OPC_JUMP);
    assign jump_take  = (!instr_i[7] || (flag_c_q == instr_i[6])) &&
                        (!instr_i[5] || (flag_z_q == instr_i[4]));
    assign jump_tgt   = JUMP_INIT[int'(instr_i[3:0])*PAW +: PAW];
    assign const_val  = CONST_INIT[int'(sy_q)*DW +: DW];
    assign port_val   = in_ports_i[int'(sy_q)*DW +: DW];

    tcc_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_jump_i (fetch_jump),
        .state_o      (state),
        .jump_now_o   (jump_now),
        .ld_ir_o      (ld_ir),
        .ld_a_o       (ld_a),
        .ld_b_o       (ld_b),
        .ld_res_o     (ld_res),
        .wb_o         (wb),
        .step_o       (step)
    );

    tcc_regfile #(.DW(DW), .NREG(N_SLOT)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wb && (op_q != OPC_OUT)),
        .waddr_i   (sx_q),
        .wdata_i   (res_q),
        .raddr_a_i (sx_q),
        .raddr_b_i (sy_q),
        .rdata_a_o (rf_a),
        .rdata_b_o (rf_b)
    );

    tcc_alu #(.DW(DW)) u_alu (
        .op_i      (op_q),
        .sub_i     (sy_q),
        .a_i       (opa_q),
        .b_i       (opb_q),
        .cin_i     (flag_c_q),
        .res_o     (alu_res),
        .cout_o    (alu_c),
        .zout_o    (alu_z),
        .flag_we_o (alu_fw)
    );

    always_comb begin
        if (op_q == OPC_IN) opb_d = port_val;
        else if (op_q[3])   opb_d = rf_b;
        else                opb_d = const_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc_q <= '0;
        else if (jump_now) pc_q <= jump_take ? jump_tgt : pc_q + PAW'(1);
        else if (step)     pc_q <= pc_q + PAW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q     <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
            res_q    <= '0;
            flag_c_q <= 1'b0;
            flag_z_q <= 1'b0;
        end else begin
            if (ld_ir) ir_q  <= instr_i;
            if (ld_a)  opa_q <= rf_a;
            if (ld_b)  opb_q <= opb_d;
            if (ld_res) begin
                res_q <= alu_res;
                if (alu_fw) begin
                    flag_c_q <= alu_c;
                    flag_z_q <= alu_z;
                end
            end
        end
    end

    assign out_wr_o   = wb && (op_q == OPC_OUT);
    assign out_sel_o  = sy_q;
    assign out_data_o = opa_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) outp_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_SLOT; i++)
                if (out_wr_o && (sy_q == SEL_W'(i))) outp_q[i] <= opa_q;
        end
    end

    for (genvar g = 0; g < N_SLOT; g++) begin : g_outp
        assign out_ports_o[g*DW +: DW] = outp_q[g];
    end

    assign pc_o = pc_q;

    // R2: the address only moves at a jump or at the closing phase
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPA || state == ST_OPB || state == ST_EXEC || state == ST_WB ||
         (state == ST_FETCH && !fetch_jump)) |=> $stable(pc_q));

    // R3: a taken jump lands on the table entry it pointed at
    p_jump_tgt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_now && jump_take) |=> (pc_q == $past(jump_tgt)));

    // R5: logic operations leave carry clear
    p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && !op_q[2] && op_q[1:0] != 2'b11) |=> !flag_c_q);

    // R7: load, input and output keep both flags
    p_flags_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && (op_q == OPC_IN || op_q == OPC_OUT || op_q[2:0] == 3'b011))
        |=> $stable({flag_c_q, flag_z_q}));

    // R8: the write strobe is a single-cycle pulse
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_o |=> !out_wr_o);

    // R8: output ports change only after a strobe
    p_port_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr_o |=> $stable(out_ports_o));

    // R10: stepping past the top address wraps to zero
    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pc_q == '1) |=> (pc_q == '0));

endmodule

// File: tb/tiny_ctrl_core_bench.sv
`timescale 1ns/1ps
module tiny_ctrl_core_bench;

    localparam int DW  = 8;
    localparam int PAW = 8;
    localparam logic [16*DW-1:0] CT = {8'h9D, 8'h10, 8'hFE, 8'h01, 8'hC3, 8'h33, 8'h0F, 8'hAA,
                                       8'h55, 8'h7F, 8'h80, 8'hFF, 8'h00, 8'h01, 8'hF0, 8'h04};
    localparam logic [16*PAW-1:0] JT = {8'h60, 8'hA5, 8'h7A, 8'h33, 8'hE0, 8'hC0, 8'h01, 8'hFE,
                                        8'h40, 8'h20, 8'h10, 8'h80, 8'hFF, 8'h00, 8'h05, 8'h09};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       instr;
    logic [PAW-1:0]    pc_o;
    logic [16*DW-1:0]  in_bus = '0;
    logic [16*DW-1:0]  out_ports;
    logic              out_wr;
    logic [3:0]        out_sel;
    logic [DW-1:0]     out_data;

    logic [11:0] prog [256];
    assign instr = prog[pc_o];

    always #10 clk = ~clk;

    tiny_ctrl_core #(.DW(DW), .PAW(PAW), .CONST_INIT(CT), .JUMP_INIT(JT)) u_tiny_ctrl_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_i     (instr),
        .pc_o        (pc_o),
        .in_ports_i  (in_bus),
        .out_ports_o (out_ports),
        .out_wr_o    (out_wr),
        .out_sel_o   (out_sel),
        .out_data_o  (out_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0]     m_reg [16];
    logic           m_c, m_z;
    logic [PAW-1:0] m_pc;
    string          m_tag [16];
    string          m_ftag;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctab(input logic [3:0] i);
        return CT[int'(i)*8 +: 8];
    endfunction

    function automatic logic [PAW-1:0] jtab(input logic [3:0] i);
        return JT[int'(i)*PAW +: PAW];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pc_o == '0, "R1 address in reset", pc_o, 0);
        check(out_ports == '0, "R1 ports in reset", out_ports[63:0], 0);
        check(!out_wr, "R1 strobe in reset", out_wr, 0);
        for (int i = 0; i < 16; i++) begin
            m_reg[i] = '0;
            m_tag[i] = "R1";
        end
        m_c = 1'b0; m_z = 1'b0; m_pc = '0; m_ftag = "R1";
        rst_n = 1'b1;
    endtask

    // Executes one instruction; entered at the falling edge of its first cycle.
    task automatic step_instr();
        logic [11:0] w;
        logic [3:0]  op, x, y;
        logic [7:0]  a, b, r, inval;
        logic [8:0]  wide;
        logic        nc, nz, fw, wr, fill, take;
        logic [PAW-1:0] npc;
        int          ncyc;
        string       tg, pctag;
        w = prog[m_pc];
        op = w[11:8]; x = w[7:4]; y = w[3:0];
        a = m_reg[x];
        inval = 8'($urandom);
        r = '0; nc = m_c; fw = 1'b0; wr = 1'b0; tg = "R2"; wide = '0; fill = 1'b0;
        if (op == 4'b0111) begin
            take = (!w[7] || m_c == w[6]) && (!w[5] || m_z == w[4]);
            npc = take ? jtab(y) : m_pc + 1'b1;
            ncyc = 1;
            pctag = {"R3 flags from ", m_ftag};
        end else begin
            if (op == 4'b1110) b = inval;
            else if (op[3])    b = m_reg[y];
            else               b = ctab(y);
            case (op)
                4'b1101, 4'b0101: begin
                    wide = a + b + m_c; r = wide[7:0]; nc = wide[8]; fw = 1; wr = 1;
                    tg = op[3] ? "R4" : "R6";
                end
                4'b1100, 4'b0100: begin
                    wide = {1'b0, a} - {1'b0, b} - m_c; r = wide[7:0]; nc = wide[8]; fw = 1; wr = 1;
                    tg = op[3] ? "R4" : "R6";
                end
                4'b1000, 4'b0000: begin r = a | b; nc = 0; fw = 1; wr = 1; tg = op[3] ? "R5" : "R6"; end
                4'b1001, 4'b0001: begin r = a & b; nc = 0; fw = 1; wr = 1; tg = op[3] ? "R5" : "R6"; end
                4'b1010, 4'b0010: begin r = a ^ b; nc = 0; fw = 1; wr = 1; tg = op[3] ? "R5" : "R6"; end
                4'b1011, 4'b0011: begin r = b; wr = 1; tg = op[3] ? "R5" : "R6"; end
                4'b1110: begin r = b; wr = 1; tg = "R7"; end
                4'b0110: begin
                    case (y[2:1])
                        2'b00: fill = m_c;
                        2'b01: fill = a[7];
                        2'b10: fill = a[0];
                        default: fill = y[0];
                    endcase
                    if (y[3]) begin nc = a[0]; r = (a >> 1) | {fill, 7'b0}; end
                    else      begin nc = a[7]; r = (a << 1) | {7'b0, fill}; end
                    fw = 1; wr = 1; tg = "R9";
                end
                default: ;
            endcase
            nz = (r == 8'h00);
            npc = m_pc + 1'b1;
            ncyc = 6;
            pctag = (m_pc == '1) ? "R10 wrap" : "R2 six-cycle step";
            if (fw) begin m_c = nc; m_z = nz; m_ftag = tg; end
        end
        for (int k = 0; k < ncyc; k++) begin
            in_bus = {$urandom, $urandom, $urandom, $urandom};
            if (op == 4'b1110) in_bus[int'(y)*8 +: 8] = (k == 2) ? inval : ~inval;
            if (op == 4'b1111 && k == 4) begin
                check(out_wr, "R8 strobe in fifth cycle", out_wr, 1);
                check(out_sel == y, "R8 port index", out_sel, y);
                check(out_data == a, {"R8 data written by ", m_tag[x]}, out_data, a);
            end else begin
                check(!out_wr, "R8 strobe idle", out_wr, 0);
            end
            if (op == 4'b1111 && k == 5)
                check(out_ports[int'(y)*8 +: 8] == a, {"R8 port holds value from ", m_tag[x]},
                      out_ports[int'(y)*8 +: 8], a);
            @(posedge clk);
            @(negedge clk);
        end
        if (wr) begin m_reg[x] = r; m_tag[x] = tg; end
        check(pc_o == npc, pctag, pc_o, npc);
        m_pc = npc;
    endtask

    task automatic run_mult(input logic [3:0] ma, input logic [3:0] mb);
        bit seen;
        in_bus = '0;
        in_bus[7:0] = {ma, mb};
        seen = 0;
        for (int n = 0; n < 3000 && !seen; n++) begin
            @(negedge clk);
            if (out_wr && out_sel == 4'd1) seen = 1;
        end
        check(seen, "R4 multiply output appears", seen, 1);
        if (seen) check(out_data == ma * mb, "R4 multiply product", out_data, ma * mb);
    endtask

    initial begin
        logic [3:0] ra, rb;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) prog[i] = 12'h702;
        prog[0]  = 12'h330; prog[1]  = 12'hA22; prog[2]  = 12'hE00; prog[3]  = 12'hB10;
        prog[4]  = 12'h111; prog[5]  = 12'h60E; prog[6]  = 12'h780; prog[7]  = 12'h811;
        prog[8]  = 12'hD21; prog[9]  = 12'h628; prog[10] = 12'h432; prog[11] = 12'h721;
        prog[12] = 12'hF21; prog[13] = 12'h702;
        in_bus = '0;
        in_bus[7:0] = 8'hFF;
        do_reset();
        run_mult(4'hF, 4'hF);
        run_mult(4'h0, 4'h9);
        run_mult(4'h9, 4'h0);
        run_mult(4'h7, 4'hD);
        run_mult(4'h1, 4'h1);
        for (int t = 0; t < 3; t++) begin
            ra = 4'($urandom); rb = 4'($urandom);
            run_mult(ra, rb);
        end
        for (int i = 0; i < 256; i++) prog[i] = 12'($urandom);
        prog[0]   = 12'h7C4;
        prog[1]   = 12'h733;
        prog[2]   = 12'h708;
        prog[254] = 12'h354;
        prog[255] = 12'h554;
        @(negedge clk);
        do_reset();
        for (int s = 0; s < 1500; s++) step_instr();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule